// File: doc/BRIEF.md
# Blocking fetch and memory sequencer

This block is the control sequencer of a non-pipelined, single-issue processor core. It keeps one request in flight at a time. First it sends an instruction fetch on the instruction port and waits for the reply. The reply carries the pre-decoded class of the instruction. The sequencer then either retires the instruction at once, or sends one load or store on the data port and waits for that reply before it retires. Decode, execution, address translation and caches are outside the block. Their results reach the sequencer as plain inputs: an operation class with its access fields, and two fault flags.

Both ports use a request strobe with a ready input. A request whose ready is low is refused. The sequencer then parks in a retry state for that port and holds the request. When the port later raises its retry strobe, the held request goes out again and the sequencer waits for the response. The program counter doubles as the held fetch address, and a register holds the refused data request. Activation starts fetching after a 16-bit cycle delay. Suspension takes effect only at an instruction boundary, and a switch-out request parks the sequencer for good until reset.

Top module: `fmseq_top`

## Requirements
- R1: After synchronous reset, `state_o` is 0 (idle), no request strobe is high, `pc_o` equals RESET_PC (default 0x100), and both `proto_err_o` and `swout_ack_o` are 0.
- R2: `activate_i` in the idle state, with a delay D on `delay_i`, moves the state to 1 (running) on the next edge. The first fetch strobe is high D cycles after that, so with D = 0 it is high in the first running cycle. `activate_i` in any other state is ignored.
- R3: A fetch strobe with `ireq_ready_i` low moves the state to 2 (fetch retry). The strobe then stays low and `pc_o` does not change. An `iretry_i` pulse in state 2 raises the fetch strobe in that same cycle with the same address, and the state becomes 3 (fetch wait).
- R4: A fetch strobe with `ireq_ready_i` high moves the state to 3 (fetch wait).
- R5: A fetch response in state 3 for a non-memory operation (`op_mem_i` low) or a prefetch (`op_prefetch_i` high) sends no data request. It pulses `retire_o`, advances `pc_o` by INST_BYTES (default 4) and returns to state 1, and the next fetch goes out in the cycle after.
- R6: A fetch response in state 3 for a load or store raises the data strobe in the same cycle, carrying `op_addr_i`, `op_size_i`, `op_wdata_i` and write = `op_store_i`. If ready is high the state becomes 5 (data wait); if ready is low it becomes 4 (data retry). A `dretry_i` pulse in state 4 re-presents the captured fields, even if the op inputs have changed, and moves the state to 5. A data response in state 5 retires, advances `pc_o` by INST_BYTES and returns to state 1.
- R7: If `fetch_fault_i` is high in a fetch cycle, no fetch strobe is raised. If `op_fault_i` is high with the fetch response, no data strobe is raised. In both cases `retire_o` pulses, `pc_o` becomes FAULT_VEC (default 0x40) and the state is 1.
- R8: `suspend_i` in state 1 suppresses the fetch of that cycle and moves the state to 0. In any other state it is ignored.
- R9: `switch_out_i` in state 1 suppresses the fetch and moves the state to 6 (switched out). In every state, `swout_ack_o` is high exactly in the cycle after a cycle with `swout_i` high.
- R10: A fetch response outside state 3, or a data response outside state 5, sets `proto_err_o`, which stays set until reset. State and `pc_o` are left unchanged.
- R11: A retry strobe outside its port's retry state raises no request and leaves the state unchanged.
- R12: The fetch and data request strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| activate_i | input | 1 | Start running (idle state only) |
| delay_i | input | CW (16) | Cycles to wait before the first fetch |
| suspend_i | input | 1 | Stop at the instruction boundary |
| swout_i | input | 1 | Switch-out request |
| swout_ack_o | output | 1 | Switch-out acknowledge, one cycle after the request |
| ireq_valid_o | output | 1 | Fetch request strobe |
| ireq_ready_i | input | 1 | Fetch port accepts the request this cycle |
| ireq_addr_o | output | AW | Fetch address |
| iretry_i | input | 1 | Fetch port asks for the held request |
| irsp_valid_i | input | 1 | Fetch response |
| fetch_fault_i | input | 1 | Fault while setting up the fetch |
| op_mem_i | input | 1 | Fetched operation is a load or store |
| op_prefetch_i | input | 1 | Fetched operation is a data prefetch |
| op_store_i | input | 1 | Memory operation writes |
| op_fault_i | input | 1 | Fault on execution or on data-access initiation |
| op_addr_i | input | AW | Data access address |
| op_size_i | input | SZ_W (2) | Data access size code |
| op_wdata_i | input | DW | Store data |
| dreq_valid_o | output | 1 | Data request strobe |
| dreq_ready_i | input | 1 | Data port accepts the request this cycle |
| dreq_addr_o | output | AW | Data address |
| dreq_size_o | output | SZ_W (2) | Data size code |
| dreq_write_o | output | 1 | Data request is a write |
| dreq_wdata_o | output | DW | Write data |
| dretry_i | input | 1 | Data port asks for the held request |
| drsp_valid_i | input | 1 | Data response |
| pc_o | output | AW | Program counter |
| state_o | output | 3 | Sequencer state code |
| retire_o | output | 1 | Instruction completes this cycle |
| proto_err_o | output | 1 | Sticky stray-response flag |

## Verification
The sequencer's state is exported on `state_o`, so a wrong transition can be seen at the next sampling point. Most faults show up even sooner in the request stream. A missed retry state leads to a fetch or data strobe that arrives early or never arrives. A wrong held register shows up as a data request whose fields do not match the ones that were refused. A wrong program-counter update shows up in the address of the very next fetch, one cycle after retirement. The scoreboard compares every strobe against the expected request in order, so an extra, missing or reordered request causes a mismatch in the cycle where it happens.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;

    localparam int SZ_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_IRETRY = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_DRETRY = 3'd4,
        ST_DWAIT  = 3'd5,
        ST_SWOUT  = 3'd6
    } seq_state_e;

    // A fetched operation needs the data port only when it is a real load/store
    function automatic logic needs_data(input logic is_mem, input logic is_pref);
        return is_mem && !is_pref;
    endfunction

endpackage

// File: rtl/fmseq_delay.sv
module fmseq_delay #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    input  logic          clr_i,
    input  logic          dec_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (load_i)   cnt_q <= val_i;
        else if (dec_i)    cnt_q <= cnt_q - CW'(1);
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fmseq_dhold.sv
module fmseq_dhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;

    always_ff @(posedge clk) begin
        if (rst)        q_q <= '0;
        else if (cap_i) q_q <= d_i;
    end

    assign q_o = q_q;
endmodule

// File: rtl/fmseq_pc.sv
module fmseq_pc #(
    parameter int              AW         = 32,
    parameter logic [AW-1:0]   RESET_PC   = 'h100,
    parameter logic [AW-1:0]   FAULT_VEC  = 'h40,
    parameter int              INST_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic          fault_i,
    output logic [AW-1:0] pc_o
);
    localparam logic [AW-1:0] STEP_V = AW'(INST_BYTES);

    logic [AW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= RESET_PC;
        else if (fault_i) pc_q <= FAULT_VEC;
        else if (adv_i)   pc_q <= pc_q + STEP_V;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/fmseq_fsm.sv
module fmseq_fsm
    import fmseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       activate_i,
    input  logic       suspend_i,
    input  logic       swout_i,
    input  logic       dly_zero_i,
    input  logic       ireq_ready_i,
    input  logic       iretry_i,
    input  logic       irsp_valid_i,
    input  logic       fetch_fault_i,
    input  logic       op_mem_i,
    input  logic       op_prefetch_i,
    input  logic       op_fault_i,
    input  logic       dreq_ready_i,
    input  logic       dretry_i,
    input  logic       drsp_valid_i,
    output logic [2:0] state_o,
    output logic       ivalid_o,
    output logic       dfresh_o,
    output logic       dheld_o,
    output logic       dcap_o,
    output logic       dly_load_o,
    output logic       dly_clr_o,
    output logic       dly_dec_o,
    output logic       pc_adv_o,
    output logic       pc_fault_o,
    output logic       retire_o,
    output logic       err_o,
    output logic       ack_o
);
    seq_state_e st_q, st_d;
    logic       err_q, ack_q, err_set;

    always_comb begin
        st_d       = st_q;
        ivalid_o   = 1'b0;
        dfresh_o   = 1'b0;
        dheld_o    = 1'b0;
        dcap_o     = 1'b0;
        dly_load_o = 1'b0;
        dly_clr_o  = 1'b0;
        dly_dec_o  = 1'b0;
        pc_adv_o   = 1'b0;
        pc_fault_o = 1'b0;
        retire_o   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (activate_i) begin
                    st_d       = ST_RUN;
                    dly_load_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (swout_i) begin
                    st_d      = ST_SWOUT;
                    dly_clr_o = 1'b1;
                end else if (suspend_i) begin
                    st_d      = ST_IDLE;
                    dly_clr_o = 1'b1;
                end else if (!dly_zero_i) begin
                    dly_dec_o = 1'b1;
                end else if (fetch_fault_i) begin
                    pc_fault_o = 1'b1;
                    retire_o   = 1'b1;
                end else begin
                    ivalid_o = 1'b1;
                    st_d     = ireq_ready_i ? ST_IWAIT : ST_IRETRY;
                end
            end
            ST_IRETRY: begin
                if (iretry_i) begin
                    ivalid_o = 1'b1;
                    st_d     = ST_IWAIT;
                end
            end
            ST_IWAIT: begin
                if (irsp_valid_i) begin
                    if (op_fault_i) begin
                        pc_fault_o = 1'b1;
                        retire_o   = 1'b1;
                        st_d       = ST_RUN;
                    end else if (needs_data(op_mem_i, op_prefetch_i)) begin
                        dfresh_o = 1'b1;
                        dcap_o   = 1'b1;
                        st_d     = dreq_ready_i ? ST_DWAIT : ST_DRETRY;
                    end else begin
                        pc_adv_o = 1'b1;
                        retire_o = 1'b1;
                        st_d     = ST_RUN;
                    end
                end
            end
            ST_DRETRY: begin
                if (dretry_i) begin
                    dheld_o = 1'b1;
                    st_d    = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (drsp_valid_i) begin
                    pc_adv_o = 1'b1;
                    retire_o = 1'b1;
                    st_d     = ST_RUN;
                end
            end
            ST_SWOUT: begin
                st_d = ST_SWOUT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign err_set = (irsp_valid_i && st_q != ST_IWAIT) ||
                     (drsp_valid_i && st_q != ST_DWAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_q | err_set;
            ack_q <= swout_i;
        end
    end

    assign state_o = st_q;
    assign err_o   = err_q;
    assign ack_o   = ack_q;
endmodule

// File: rtl/fmseq_top.sv
module fmseq_top
    import fmseq_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter int            CW         = 16,
    parameter logic [AW-1:0] RESET_PC   = 'h100,
    parameter logic [AW-1:0] FAULT_VEC  = 'h40,
    parameter int            INST_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            activate_i,
    input  logic [CW-1:0]   delay_i,
    input  logic            suspend_i,
    input  logic            swout_i,
    output logic            swout_ack_o,
    output logic            ireq_valid_o,
    input  logic            ireq_ready_i,
    output logic [AW-1:0]   ireq_addr_o,
    input  logic            iretry_i,
    input  logic            irsp_valid_i,
    input  logic            fetch_fault_i,
    input  logic            op_mem_i,
    input  logic            op_prefetch_i,
    input  logic            op_store_i,
    input  logic            op_fault_i,
    input  logic [AW-1:0]   op_addr_i,
    input  logic [SZ_W-1:0] op_size_i,
    input  logic [DW-1:0]   op_wdata_i,
    output logic            dreq_valid_o,
    input  logic            dreq_ready_i,
    output logic [AW-1:0]   dreq_addr_o,
    output logic [SZ_W-1:0] dreq_size_o,
    output logic            dreq_write_o,
    output logic [DW-1:0]   dreq_wdata_o,
    input  logic            dretry_i,
    input  logic            drsp_valid_i,
    output logic [AW-1:0]   pc_o,
    output logic [2:0]      state_o,
    output logic            retire_o,
    output logic            proto_err_o
);
    typedef struct packed {
        logic [AW-1:0]   addr;
        logic [SZ_W-1:0] size;
        logic            write;
        logic [DW-1:0]   wdata;
    } dreq_t;

    localparam int DREQ_W = $bits(dreq_t);

    dreq_t fresh, held, sel;
    logic  ivalid, dfresh, dheld, dcap;
    logic  dly_load, dly_clr, dly_dec, dly_zero;
    logic  pc_adv, pc_fault;

    assign fresh = '{addr: op_addr_i, size: op_size_i, write: op_store_i, wdata: op_wdata_i};

    fmseq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .activate_i   (activate_i),
        .suspend_i    (suspend_i),
        .swout_i      (swout_i),
        .dly_zero_i   (dly_zero),
        .ireq_ready_i (ireq_ready_i),
        .iretry_i     (iretry_i),
        .irsp_valid_i (irsp_valid_i),
        .fetch_fault_i(fetch_fault_i),
        .op_mem_i     (op_mem_i),
        .op_prefetch_i(op_prefetch_i),
        .op_fault_i   (op_fault_i),
        .dreq_ready_i (dreq_ready_i),
        .dretry_i     (dretry_i),
        .drsp_valid_i (drsp_valid_i),
        .state_o      (state_o),
        .ivalid_o     (ivalid),
        .dfresh_o     (dfresh),
        .dheld_o      (dheld),
        .dcap_o       (dcap),
        .dly_load_o   (dly_load),
        .dly_clr_o    (dly_clr),
        .dly_dec_o    (dly_dec),
        .pc_adv_o     (pc_adv),
        .pc_fault_o   (pc_fault),
        .retire_o     (retire_o),
        .err_o        (proto_err_o),
        .ack_o        (swout_ack_o)
    );

    fmseq_delay #(.CW(CW)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .load_i(dly_load),
        .val_i (delay_i),
        .clr_i (dly_clr),
        .dec_i (dly_dec),
        .zero_o(dly_zero)
    );

    fmseq_dhold #(.W(DREQ_W)) u_dhold (
        .clk  (clk),
        .rst  (rst),
        .cap_i(dcap),
        .d_i  (fresh),
        .q_o  (held)
    );

    fmseq_pc #(
        .AW        (AW),
        .RESET_PC  (RESET_PC),
        .FAULT_VEC (FAULT_VEC),
        .INST_BYTES(INST_BYTES)
    ) u_pc (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (pc_adv),
        .fault_i(pc_fault),
        .pc_o   (pc_o)
    );

    // The program counter is itself the held fetch request
    assign ireq_valid_o = ivalid;
    assign ireq_addr_o  = pc_o;

    assign sel          = dheld ? held : fresh;
    assign dreq_valid_o = dfresh | dheld;
    assign dreq_addr_o  = sel.addr;
    assign dreq_size_o  = sel.size;
    assign dreq_write_o = sel.write;
    assign dreq_wdata_o = sel.wdata;
endmodule

// File: rtl/fmseq_chk.sv
module fmseq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    state_o,
    input logic          ireq_valid_o,
    input logic          ireq_ready_i,
    input logic          dreq_valid_o,
    input logic          dreq_ready_i,
    input logic [AW-1:0] pc_o,
    input logic          proto_err_o,
    input logic          swout_i,
    input logic          swout_ack_o,
    input logic          retire_o
);
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
        !(ireq_valid_o && dreq_valid_o)); // R12
    AST_IREFUSE_PARKS: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && ireq_valid_o && !ireq_ready_i) |=> (state_o == 3'd2)); // R3
    AST_IRETRY_PC_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2) |=> $stable(pc_o)); // R3
    AST_IACCEPT_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && ireq_valid_o && ireq_ready_i) |=> (state_o == 3'd3)); // R4
    AST_DREFUSE_PARKS: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && dreq_valid_o && !dreq_ready_i) |=> (state_o == 3'd4)); // R6
    AST_RETIRE_RUNS: assert property (@(posedge clk) disable iff (rst)
        retire_o |=> (state_o == 3'd1)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0) |-> (!ireq_valid_o && !dreq_valid_o)); // R8
    AST_SWOUT_ACK: assert property (@(posedge clk) disable iff (rst)
        swout_i |=> swout_ack_o); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o); // R10
endmodule

bind fmseq_top fmseq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state_o     (state_o),
    .ireq_valid_o(ireq_valid_o),
    .ireq_ready_i(ireq_ready_i),
    .dreq_valid_o(dreq_valid_o),
    .dreq_ready_i(dreq_ready_i),
    .pc_o        (pc_o),
    .proto_err_o (proto_err_o),
    .swout_i     (swout_i),
    .swout_ack_o (swout_ack_o),
    .retire_o    (retire_o)
);

// File: tb/test_fmseq_top.sv
`timescale 1ns/1ps
module test_fmseq_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int IW = 4 + AW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          activate_i = 1'b0;
    logic [CW-1:0] delay_i = '0;
    logic          suspend_i = 1'b0, swout_i = 1'b0, swout_ack_o;
    logic          ireq_valid_o, ireq_ready_i = 1'b1, iretry_i = 1'b0, irsp_valid_i = 1'b0;
    logic [AW-1:0] ireq_addr_o;
    logic          fetch_fault_i = 1'b0, op_mem_i = 1'b0, op_prefetch_i = 1'b0;
    logic          op_store_i = 1'b0, op_fault_i = 1'b0;
    logic [AW-1:0] op_addr_i = '0;
    logic [1:0]    op_size_i = '0;
    logic [DW-1:0] op_wdata_i = '0;
    logic          dreq_valid_o, dreq_ready_i = 1'b1, dreq_write_o, dretry_i = 1'b0, drsp_valid_i = 1'b0;
    logic [AW-1:0] dreq_addr_o;
    logic [1:0]    dreq_size_o;
    logic [DW-1:0] dreq_wdata_o;
    logic [AW-1:0] pc_o;
    logic [2:0]    state_o;
    logic          retire_o, proto_err_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [IW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    fmseq_top i_fmseq_top (
        .clk(clk), .rst(rst), .activate_i(activate_i), .delay_i(delay_i),
        .suspend_i(suspend_i), .swout_i(swout_i), .swout_ack_o(swout_ack_o),
        .ireq_valid_o(ireq_valid_o), .ireq_ready_i(ireq_ready_i), .ireq_addr_o(ireq_addr_o),
        .iretry_i(iretry_i), .irsp_valid_i(irsp_valid_i), .fetch_fault_i(fetch_fault_i),
        .op_mem_i(op_mem_i), .op_prefetch_i(op_prefetch_i), .op_store_i(op_store_i),
        .op_fault_i(op_fault_i), .op_addr_i(op_addr_i), .op_size_i(op_size_i),
        .op_wdata_i(op_wdata_i), .dreq_valid_o(dreq_valid_o), .dreq_ready_i(dreq_ready_i),
        .dreq_addr_o(dreq_addr_o), .dreq_size_o(dreq_size_o), .dreq_write_o(dreq_write_o),
        .dreq_wdata_o(dreq_wdata_o), .dretry_i(dretry_i), .drsp_valid_i(drsp_valid_i),
        .pc_o(pc_o), .state_o(state_o), .retire_o(retire_o), .proto_err_o(proto_err_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic neg();
        @(negedge clk);
    endtask

    task automatic push_fetch(input logic [AW-1:0] a);
        exp_q.push_back({1'b0, 1'b0, 2'b00, a, {DW{1'b0}}});
    endtask

    task automatic push_data(input logic w, input logic [1:0] s, input logic [AW-1:0] a,
                             input logic [DW-1:0] d);
        exp_q.push_back({1'b1, w, s, a, d});
    endtask

    task automatic pop_cmp(input string tag, input logic [IW-1:0] act);
        logic [IW-1:0] e;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL %s unexpected request actual=%0h expected=none", tag, act);
        end else begin
            e = exp_q.pop_front();
            if (act !== e) begin
                n_err++;
                $display("FAIL %s request actual=%0h expected=%0h", tag, act, e);
            end
        end
    endtask

    // Monitor: every request strobe is matched in order against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ireq_valid_o && dreq_valid_o) begin
                n_chk++;
                n_err++;
                $display("FAIL R12 both strobes actual=11 expected=one");
            end
            if (ireq_valid_o)
                pop_cmp("R3 fetch", {1'b0, 1'b0, 2'b00, ireq_addr_o, {DW{1'b0}}});
            if (dreq_valid_o)
                pop_cmp("R6 data", {1'b1, dreq_write_o, dreq_size_o, dreq_addr_o, dreq_wdata_o});
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        neg();
        chk("R1 state", 64'(state_o), 64'd0);
        chk("R1 pc", 64'(pc_o), 64'h100);
        chk("R1 strobes", 64'({ireq_valid_o, dreq_valid_o}), 64'd0);
        chk("R1 flags", 64'({proto_err_o, swout_ack_o}), 64'd0);

        // R2: activation with delay 3
        cyc(); activate_i = 1'b1; delay_i = 16'd3;
        cyc(); activate_i = 1'b0; neg();
        chk("R2 running", 64'(state_o), 64'd1);
        chk("R2 no early fetch", 64'(ireq_valid_o), 64'd0);
        cyc(); neg();
        cyc(); neg();
        chk("R2 still waiting", 64'(ireq_valid_o), 64'd0);
        cyc(); push_fetch(32'h100); ireq_ready_i = 1'b1; neg();
        chk("R2 fetch after delay", 64'(ireq_valid_o), 64'd1);

        // R4 then R5 non-memory op
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b0; neg();
        chk("R4 fetch wait", 64'(state_o), 64'd3);
        chk("R5 retire alu", 64'(retire_o), 64'd1);
        cyc(); irsp_valid_i = 1'b0; push_fetch(32'h104); ireq_ready_i = 1'b0; neg();
        chk("R5 pc advance", 64'(pc_o), 64'h104);

        // R3 refused fetch and retry
        cyc(); ireq_ready_i = 1'b1; neg();
        chk("R3 retry state", 64'(state_o), 64'd2);
        chk("R3 strobe low", 64'(ireq_valid_o), 64'd0);
        cyc(); iretry_i = 1'b1; push_fetch(32'h104); neg();
        cyc(); iretry_i = 1'b0; neg();
        chk("R3 wait after retry", 64'(state_o), 64'd3);

        // R5 prefetch completes without data port
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b1; op_prefetch_i = 1'b1; neg();
        chk("R5 retire prefetch", 64'(retire_o), 64'd1);
        cyc(); irsp_valid_i = 1'b0; op_mem_i = 1'b0; op_prefetch_i = 1'b0; push_fetch(32'h108); neg();
        chk("R5 pc after prefetch", 64'(pc_o), 64'h108);

        // R6 accepted load
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b1; op_store_i = 1'b0;
        op_addr_i = 32'h2000; op_size_i = 2'd2; op_wdata_i = '0; dreq_ready_i = 1'b1;
        push_data(1'b0, 2'd2, 32'h2000, 32'h0); neg();
        cyc(); irsp_valid_i = 1'b0; op_mem_i = 1'b0; neg();
        chk("R6 data wait", 64'(state_o), 64'd5);
        chk("R6 pc held", 64'(pc_o), 64'h108);
        cyc(); drsp_valid_i = 1'b1; neg();
        chk("R6 retire load", 64'(retire_o), 64'd1);
        cyc(); drsp_valid_i = 1'b0; push_fetch(32'h10C); neg();
        chk("R6 pc after load", 64'(pc_o), 64'h10C);

        // R6 refused store, R11 stray fetch retry
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b1; op_store_i = 1'b1;
        op_addr_i = 32'h3000; op_size_i = 2'd1; op_wdata_i = 32'hDEADBEEF; dreq_ready_i = 1'b0;
        push_data(1'b1, 2'd1, 32'h3000, 32'hDEADBEEF); neg();
        cyc(); irsp_valid_i = 1'b0; op_mem_i = 1'b0; op_store_i = 1'b0;
        op_addr_i = 32'h5555; op_size_i = 2'd0; op_wdata_i = '0; dreq_ready_i = 1'b1;
        iretry_i = 1'b1; neg();
        chk("R6 data retry", 64'(state_o), 64'd4);
        chk("R11 no fetch on stray retry", 64'(ireq_valid_o), 64'd0);
        cyc(); iretry_i = 1'b0; neg();
        chk("R11 state unchanged", 64'(state_o), 64'd4);
        cyc(); dretry_i = 1'b1; push_data(1'b1, 2'd1, 32'h3000, 32'hDEADBEEF); neg();
        cyc(); dretry_i = 1'b0; neg();
        chk("R6 wait after data retry", 64'(state_o), 64'd5);
        cyc(); drsp_valid_i = 1'b1; neg();

        // R7 fetch-setup fault
        cyc(); drsp_valid_i = 1'b0; fetch_fault_i = 1'b1; neg();
        chk("R7 retire on fetch fault", 64'(retire_o), 64'd1);
        chk("R7 no fetch strobe", 64'(ireq_valid_o), 64'd0);
        cyc(); fetch_fault_i = 1'b0; push_fetch(32'h40); neg();
        chk("R7 handler pc", 64'(pc_o), 64'h40);

        // R10 stray response, R8 and R2 ignored controls
        cyc(); drsp_valid_i = 1'b1; suspend_i = 1'b1; activate_i = 1'b1; neg();
        chk("R10 no retire on stray", 64'(retire_o), 64'd0);
        cyc(); drsp_valid_i = 1'b0; suspend_i = 1'b0; activate_i = 1'b0; neg();
        chk("R10 error set", 64'(proto_err_o), 64'd1);
        chk("R8 suspend ignored in wait", 64'(state_o), 64'd3);
        chk("R10 pc unchanged", 64'(pc_o), 64'h40);
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b0; neg();
        cyc(); irsp_valid_i = 1'b0; push_fetch(32'h44); neg();

        // R7 initiation fault on a load
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b1; op_fault_i = 1'b1; neg();
        chk("R7 retire on op fault", 64'(retire_o), 64'd1);
        chk("R7 no data strobe", 64'(dreq_valid_o), 64'd0);

        // R8 suspend at boundary
        cyc(); irsp_valid_i = 1'b0; op_mem_i = 1'b0; op_fault_i = 1'b0; suspend_i = 1'b1; neg();
        chk("R7 pc to handler", 64'(pc_o), 64'h40);
        chk("R8 fetch suppressed", 64'(ireq_valid_o), 64'd0);
        cyc(); suspend_i = 1'b0; neg();
        chk("R8 idle", 64'(state_o), 64'd0);
        chk("R10 error sticky", 64'(proto_err_o), 64'd1);
        cyc(); neg();
        chk("R8 no fetch while idle", 64'(ireq_valid_o), 64'd0);

        // R2 zero delay
        cyc(); activate_i = 1'b1; delay_i = 16'd0; neg();
        cyc(); activate_i = 1'b0; push_fetch(32'h40); neg();
        chk("R2 zero delay running", 64'(state_o), 64'd1);
        chk("R2 zero delay fetch", 64'(ireq_valid_o), 64'd1);
        cyc(); irsp_valid_i = 1'b1; op_mem_i = 1'b0; neg();

        // R9 switch-out
        cyc(); irsp_valid_i = 1'b0; swout_i = 1'b1; neg();
        chk("R9 fetch suppressed", 64'(ireq_valid_o), 64'd0);
        cyc(); swout_i = 1'b0; neg();
        chk("R9 switched state", 64'(state_o), 64'd6);
        chk("R9 ack", 64'(swout_ack_o), 64'd1);
        cyc(); swout_i = 1'b1; neg();
        chk("R9 ack one cycle", 64'(swout_ack_o), 64'd0);
        cyc(); swout_i = 1'b0; neg();
        chk("R9 ack outside running", 64'(swout_ack_o), 64'd1);
        chk("R9 state kept", 64'(state_o), 64'd6);

        chk("R12 scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule